// File: doc/BRIEF.md
# Camera Register Bus Master

This block runs the two-wire control bus that an image sensor exposes for register access. The user presents an operation bit, a 7-bit device address, an 8-bit register index and, for writes, an 8-bit value, then pulses a start strobe while the block shows ready. The block then drives the serial clock and data lines and raises ready again when the bus has returned to idle. After a read, the fetched byte appears on a result output together with a valid flag.

Both bus lines are open-drain. The block never drives a line high. It has one "pull low" output per line, and it reads the data line back through a separate input. External pull-ups supply the high level.

A write is a single bus frame of three bytes. A read is two separate frames with a full stop between them. The first frame is a two-byte address write and the second is a two-byte read. Every ninth bit after a byte is a slot the master releases and does not check. The bus bit period comes from the system and bus clock frequency parameters.

Top module: `cambus_master`

## Requirements
- R1: After reset, and whenever idle, ready is 1, rd_valid is 0 and neither line is pulled low.
- R2: A start pulse is taken only while ready is 1. Ready reads 0 from the next cycle until the whole transaction ends. A start pulse while busy causes no extra bus frame.
- R3: With op_read = 0 the bus carries one frame: start condition, then bytes {dev_addr,1'b0}, reg_addr, wr_data, then stop condition.
- R4: With op_read = 1 the bus carries two frames. The first is bytes {dev_addr,1'b0} and reg_addr, then a stop. The second is a new start, byte {dev_addr,1'b1}, then one byte sent by the slave, then a stop.
- R5: Bytes are sent most significant bit first. The master leaves the ninth bit released and ignores its level, so a slave that pulls it low gives the same result.
- R6: In the read frame, the ninth bit after the slave's data byte is left high by the master (not-acknowledge).
- R7: After a read, rd_valid is 1 with rd_data equal to the byte the slave sent, by the time ready returns. rd_valid reads 0 from the cycle after the next accepted start.
- R8: A start condition is the data line falling while the clock is high. A stop condition is the data line rising while the clock is high. Within a byte, data changes only while the clock is low.
- R9: The clock is high for 2*Q and low for 2*Q system cycles per data bit, where Q = CLK_HZ/(4*BUS_HZ).
- R10: The operation, address and value inputs are captured when start is taken. Changing them afterwards does not alter the transaction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| op_read | input | 1 | Operation select: 0 write, 1 read |
| dev_addr | input | 7 | Slave device address |
| reg_addr | input | 8 | Register index |
| wr_data | input | 8 | Value to write |
| start | input | 1 | Start strobe, taken while ready |
| ready | output | 1 | Idle and able to take a start |
| rd_data | output | 8 | Byte fetched by the last read |
| rd_valid | output | 1 | rd_data holds a captured byte |
| scl_pull | output | 1 | 1 pulls the clock line low, 0 releases it |
| sda_pull | output | 1 | 1 pulls the data line low, 0 releases it |
| sda_in | input | 1 | Level sensed on the data line |

## Verification
The hardest states to reach from the ports are the ones that need a slave on the bus. These are the read frame, where a slave must drive each data bit in step with the clock, and the ninth-bit slots, where a slave might pull the line low. The bench models the wired-AND bus and includes a slave that decodes start and stop conditions and counts clock rises. It drives a chosen byte after a read header and can optionally pull every acknowledge slot low. Bus frames are rebuilt from the line levels and compared byte by byte. The same monitor measures every clock high and low period.

// File: rtl/cambus_pkg.sv
package cambus_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_START = 2'd1,
        ST_BITS  = 2'd2,
        ST_STOP  = 2'd3
    } cm_state_e;

    typedef struct packed {
        cm_state_e  state;
        logic [1:0] q;        // quarter of the current bit / condition
        logic [3:0] bitn;     // 0..7 data, 8 = ninth slot
        logic [1:0] byten;    // byte within the frame
        logic       frame;    // 0 = first frame, 1 = read frame
        logic       rd_op;
        logic [6:0] dev;
        logic [7:0] regi;
        logic [7:0] val;
        logic [7:0] shreg;
        logic [7:0] rx;
        logic [7:0] rd_data;
        logic       rd_valid;
        logic       scl_low;
        logic       sda_low;
    } cm_regs_t;

endpackage

// File: rtl/cambus_tick.sv
module cambus_tick #(
    parameter int QDIV = 30
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    output logic tick_o
);
    localparam int CW = (QDIV > 1) ? $clog2(QDIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(QDIV - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        if (!en_i)            cnt_d = '0;
        else if (cnt_q == LAST) cnt_d = '0;
        else                  cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign tick_o = en_i && (cnt_q == LAST);

    a_r9_tick_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |-> $past(en_i) || (QDIV == 1));

endmodule

// File: rtl/cambus_seq.sv
module cambus_seq
    import cambus_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick_i,
    input  logic       op_read_i,
    input  logic [6:0] dev_i,
    input  logic [7:0] reg_i,
    input  logic [7:0] val_i,
    input  logic       start_i,
    input  logic       sda_i,
    output logic       busy_o,
    output logic       ready_o,
    output logic [7:0] rd_data_o,
    output logic       rd_valid_o,
    output logic       scl_low_o,
    output logic       sda_low_o
);
    cm_regs_t r_q, r_d;

    logic rx_byte, last_byte;

    assign rx_byte   = r_q.frame && (r_q.byten == 2'd1);
    assign last_byte = r_q.rd_op ? (r_q.byten == 2'd1) : (r_q.byten == 2'd2);

    always_comb begin
        r_d = r_q;
        case (r_q.state)
            ST_IDLE: begin
                if (start_i) begin
                    r_d.state    = ST_START;
                    r_d.q        = 2'd0;
                    r_d.rd_op    = op_read_i;
                    r_d.dev      = dev_i;
                    r_d.regi     = reg_i;
                    r_d.val      = val_i;
                    r_d.frame    = 1'b0;
                    r_d.rd_valid = 1'b0;
                end
            end
            ST_START: begin
                if (tick_i) begin
                    if (r_q.q == 2'd0) begin
                        r_d.sda_low = 1'b1;          // data falls, clock high
                        r_d.q       = 2'd1;
                    end else begin
                        r_d.state   = ST_BITS;
                        r_d.q       = 2'd0;
                        r_d.bitn    = 4'd0;
                        r_d.byten   = 2'd0;
                        r_d.shreg   = {r_q.dev, r_q.frame};
                        r_d.scl_low = 1'b1;
                    end
                end
            end
            ST_BITS: begin
                if (tick_i) begin
                    case (r_q.q)
                        2'd0: begin
                            r_d.sda_low = (r_q.bitn < 4'd8 && !rx_byte) ? !r_q.shreg[7] : 1'b0;
                            r_d.q       = 2'd1;
                        end
                        2'd1: begin
                            r_d.scl_low = 1'b0;
                            r_d.q       = 2'd2;
                        end
                        2'd2: begin
                            if (rx_byte && r_q.bitn < 4'd8) begin
                                r_d.rx = {r_q.rx[6:0], sda_i};
                                if (r_q.bitn == 4'd7) begin
                                    r_d.rd_data  = {r_q.rx[6:0], sda_i};
                                    r_d.rd_valid = 1'b1;
                                end
                            end
                            r_d.q = 2'd3;
                        end
                        default: begin
                            r_d.scl_low = 1'b1;
                            r_d.q       = 2'd0;
                            if (r_q.bitn == 4'd8) begin
                                if (last_byte) begin
                                    r_d.state = ST_STOP;
                                end else begin
                                    r_d.byten = r_q.byten + 2'd1;
                                    r_d.bitn  = 4'd0;
                                    r_d.shreg = (r_q.byten == 2'd0) ? r_q.regi : r_q.val;
                                end
                            end else begin
                                r_d.bitn  = r_q.bitn + 4'd1;
                                r_d.shreg = {r_q.shreg[6:0], 1'b0};
                            end
                        end
                    endcase
                end
            end
            default: begin // ST_STOP
                if (tick_i) begin
                    case (r_q.q)
                        2'd0: begin r_d.sda_low = 1'b1; r_d.q = 2'd1; end
                        2'd1: begin r_d.scl_low = 1'b0; r_d.q = 2'd2; end
                        2'd2: begin r_d.sda_low = 1'b0; r_d.q = 2'd3; end
                        default: begin
                            r_d.q = 2'd0;
                            if (r_q.rd_op && !r_q.frame) begin
                                r_d.state = ST_START;
                                r_d.frame = 1'b1;
                            end else begin
                                r_d.state = ST_IDLE;
                            end
                        end
                    endcase
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q       <= '0;
            r_q.state <= ST_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

    assign busy_o     = (r_q.state != ST_IDLE);
    assign ready_o    = (r_q.state == ST_IDLE);
    assign rd_data_o  = r_q.rd_data;
    assign rd_valid_o = r_q.rd_valid;
    assign scl_low_o  = r_q.scl_low;
    assign sda_low_o  = r_q.sda_low;

    // R2: a taken start drops ready on the next cycle
    a_r2_ready_drops: assert property (@(posedge clk) disable iff (!rst_n)
        (ready_o && start_i) |=> !ready_o);

    // R7: valid clears on a taken start
    a_r7_valid_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (ready_o && start_i) |=> !rd_valid_o);

    // R1: idle leaves both lines released
    a_r1_idle_released: assert property (@(posedge clk) disable iff (!rst_n)
        ready_o |-> (!scl_low_o && !sda_low_o));

    // R8: inside a byte, data is steady while the clock is high
    a_r8_data_steady_high: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == ST_BITS && $past(r_q.state) == ST_BITS && !scl_low_o) |-> $stable(sda_low_o));

    // R9: the clock moves only on a quarter tick
    a_r9_clock_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(tick_i) |-> $stable(scl_low_o));

    // R6: the slot after the slave's byte is left released
    a_r6_nack_released: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == ST_BITS && rx_byte && r_q.bitn == 4'd8 && r_q.q != 2'd0) |-> !sda_low_o);

endmodule

// File: rtl/cambus_master.sv
module cambus_master #(
    parameter int CLK_HZ = 12_000_000,
    parameter int BUS_HZ = 100_000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       op_read,
    input  logic [6:0] dev_addr,
    input  logic [7:0] reg_addr,
    input  logic [7:0] wr_data,
    input  logic       start,
    output logic       ready,
    output logic [7:0] rd_data,
    output logic       rd_valid,
    output logic       scl_pull,
    output logic       sda_pull,
    input  logic       sda_in
);
    localparam int QRAW = CLK_HZ / (4 * BUS_HZ);
    localparam int QDIV = (QRAW < 1) ? 1 : QRAW;

    logic tick, busy;

    cambus_tick #(.QDIV(QDIV)) u_tick (
        .clk    (clk),
        .rst_n  (rst_n),
        .en_i   (busy),
        .tick_o (tick)
    );

    cambus_seq u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick_i     (tick),
        .op_read_i  (op_read),
        .dev_i      (dev_addr),
        .reg_i      (reg_addr),
        .val_i      (wr_data),
        .start_i    (start),
        .sda_i      (sda_in),
        .busy_o     (busy),
        .ready_o    (ready),
        .rd_data_o  (rd_data),
        .rd_valid_o (rd_valid),
        .scl_low_o  (scl_pull),
        .sda_low_o  (sda_pull)
    );

    // R2: ready never coexists with a running divider
    a_r2_ready_idle: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> !tick);

endmodule

// File: tb/tb_cambus_master.sv
`timescale 1ns/1ps
module tb_cambus_master;
    localparam int CLK_HZ = 100_000_000;
    localparam int BUS_HZ = 6_250_000;
    localparam int Q = CLK_HZ / (4 * BUS_HZ);

    logic clk = 0, rst_n = 0;
    logic op_read = 0, start = 0;
    logic [6:0] dev_addr = 0;
    logic [7:0] reg_addr = 0, wr_data = 0;
    logic ready, rd_valid, scl_pull, sda_pull;
    logic [7:0] rd_data;
    logic slave_low = 0;
    logic scl_line, sda_line;

    assign scl_line = !scl_pull;
    assign sda_line = !(sda_pull | slave_low);

    cambus_master #(.CLK_HZ(CLK_HZ), .BUS_HZ(BUS_HZ)) dut (
        .clk(clk), .rst_n(rst_n), .op_read(op_read), .dev_addr(dev_addr),
        .reg_addr(reg_addr), .wr_data(wr_data), .start(start), .ready(ready),
        .rd_data(rd_data), .rd_valid(rd_valid), .scl_pull(scl_pull),
        .sda_pull(sda_pull), .sda_in(sda_line)
    );

    always #5 clk = ~clk;

    int tests = 0, fails = 0;
    int cycles = 0;

    // bus monitor / slave model state
    logic [7:0] fb [0:3][0:3];
    logic       nine [0:3][0:3];
    int fnb [0:3];
    int nframes = 0, nstarts = 0, nstops = 0, cur = 0, bitcnt = 0;
    logic in_frame = 0, pscl = 1, psda = 1;
    logic [7:0] acc = 0;
    logic [7:0] slave_byte = 8'h00;
    logic ack_en = 0;
    int hi_len = 0, lo_len = 0, hi_bad = 0, lo_bad = 0, hi_seen = 0;
    logic hi_ok = 0, lo_ok = 0;

    task automatic chk(input logic ok, input string tag, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic clr_mon();
        nframes = 0; nstarts = 0; nstops = 0; hi_bad = 0; lo_bad = 0; hi_seen = 0;
        for (int i = 0; i < 4; i++) begin
            fnb[i] = 0;
            for (int j = 0; j < 4; j++) begin fb[i][j] = 8'h00; nine[i][j] = 1'b0; end
        end
    endtask

    always @(negedge clk) begin
        if (!rst_n) begin
            pscl = 1; psda = 1; in_frame = 0; slave_low = 0;
        end else begin
            if (scl_line && pscl && psda && !sda_line) begin
                nstarts++; cur = (nframes < 4) ? nframes : 3;
                if (nframes < 4) nframes++;
                bitcnt = 0; in_frame = 1; acc = 0; hi_ok = 0; lo_ok = 0;
            end
            if (scl_line && pscl && !psda && sda_line) begin
                nstops++; in_frame = 0; slave_low = 0; hi_ok = 0;
            end
            if (scl_line && !pscl && in_frame) begin
                int pos, byt;
                pos = bitcnt % 9; byt = bitcnt / 9;
                if (pos < 8) acc = {acc[6:0], sda_line};
                if (pos == 7 && byt < 4) begin fb[cur][byt] = acc; fnb[cur] = byt + 1; end
                if (pos == 8 && byt < 4) nine[cur][byt] = sda_line;
                bitcnt++;
                if (lo_ok && lo_len != 2*Q) lo_bad++;
                hi_len = 1; hi_ok = 1;
            end else if (scl_line) hi_len++;
            if (!scl_line && pscl && in_frame) begin
                int pos, byt;
                logic rdf;
                if (hi_ok) begin hi_seen++; if (hi_len != 2*Q) hi_bad++; end
                lo_len = 1; lo_ok = 1;
                pos = bitcnt % 9; byt = bitcnt / 9;
                rdf = (fnb[cur] >= 1) && fb[cur][0][0];
                slave_low = 0;
                if (rdf && byt == 1 && pos < 8) slave_low = !slave_byte[7-pos];
                else if (pos == 8 && ack_en && !(rdf && byt == 1)) slave_low = 1;
            end else if (!scl_line) lo_len++;
            pscl = scl_line; psda = sda_line;
        end
    end

    task automatic pulse_start();
        @(negedge clk); start = 1;
        @(negedge clk); start = 0;
    endtask

    task automatic wait_ready(input string tag);
        int n = 0;
        while (!ready && n < 20000) begin @(negedge clk); n++; end
        chk(ready, tag, 0, 1);
        repeat (4*Q) @(negedge clk);
    endtask

    task automatic t_reset();
        chk(ready == 1, "R1 ready", ready, 1);
        chk(rd_valid == 0, "R1 valid", rd_valid, 0);
        chk(!scl_pull && !sda_pull, "R1 lines", {scl_pull, sda_pull}, 0);
    endtask

    task automatic t_write(input logic [6:0] a, input logic [7:0] rg, input logic [7:0] v,
                           input logic ack, input string tag);
        clr_mon(); ack_en = ack;
        op_read = 0; dev_addr = a; reg_addr = rg; wr_data = v;
        pulse_start();
        chk(ready == 0, "R2 ready low", ready, 0);
        wait_ready("R2 done");
        chk(nframes == 1 && nstops == 1, {"R3 frames ", tag}, nframes, 1);
        chk(fnb[0] == 3, {"R3 bytes ", tag}, fnb[0], 3);
        chk(fb[0][0] == {a,1'b0}, {"R5 id ", tag}, fb[0][0], {a,1'b0});
        chk(fb[0][1] == rg, {"R3 reg ", tag}, fb[0][1], rg);
        chk(fb[0][2] == v, {"R3 val ", tag}, fb[0][2], v);
        chk(hi_bad == 0 && lo_bad == 0 && hi_seen > 20, "R9 timing", hi_bad + lo_bad, 0);
        ack_en = 0;
    endtask

    task automatic t_read(input logic [6:0] a, input logic [7:0] rg, input logic [7:0] sb,
                          input logic ack);
        clr_mon(); ack_en = ack; slave_byte = sb;
        op_read = 1; dev_addr = a; reg_addr = rg; wr_data = 8'hEE;
        pulse_start();
        chk(rd_valid == 0, "R7 valid cleared", rd_valid, 0);
        chk(ready == 0, "R2 ready low", ready, 0);
        wait_ready("R2 read done");
        chk(nframes == 2 && nstarts == 2 && nstops == 2, "R4 two frames", nframes, 2);
        chk(fnb[0] == 2 && fb[0][0] == {a,1'b0} && fb[0][1] == rg, "R4 addr frame", fb[0][1], rg);
        chk(fnb[1] == 2 && fb[1][0] == {a,1'b1}, "R4 read header", fb[1][0], {a,1'b1});
        chk(nine[1][1] == 1'b1, "R6 nack", nine[1][1], 1);
        chk(rd_valid == 1 && rd_data == sb, "R7 read data", rd_data, sb);
        chk(hi_bad == 0 && lo_bad == 0, "R9 timing read", hi_bad + lo_bad, 0);
        ack_en = 0;
    endtask

    task automatic t_busy_and_change();
        clr_mon();
        op_read = 0; dev_addr = 7'h35; reg_addr = 8'h81; wr_data = 8'h7E;
        pulse_start();
        // R10: change inputs once busy; R2: extra start while busy
        op_read = 1; dev_addr = 7'h0A; reg_addr = 8'h00; wr_data = 8'h11;
        repeat (30) @(negedge clk);
        pulse_start();
        wait_ready("R2 busy done");
        repeat (20*Q) @(negedge clk);
        chk(nframes == 1 && ready, "R2 busy start ignored", nframes, 1);
        chk(fb[0][0] == {7'h35,1'b0} && fb[0][1] == 8'h81 && fb[0][2] == 8'h7E,
            "R10 captured inputs", fb[0][2], 8'h7E);
    endtask

    initial begin
        clr_mon();
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1;
        repeat (3) @(negedge clk);
        t_reset();
        t_write(7'h21, 8'h18, 8'h58, 0, "plain");
        t_write(7'h21, 8'h18, 8'h58, 1, "acked");     // R5 ack level ignored
        t_write(7'h7F, 8'hFF, 8'h00, 0, "edges");
        t_read(7'h21, 8'h18, 8'h9C, 0);
        t_read(7'h42, 8'h0A, 8'hFF, 1);               // R5 ack slots pulled, same result
        t_read(7'h00, 8'h55, 8'h00, 0);
        t_write(7'h10, 8'h20, 8'h30, 0, "after read"); // R7 clears on next start
        chk(rd_valid == 0, "R7 valid after write", rd_valid, 0);
        t_busy_and_change();
        t_reset();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            tests++; fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule